// File: doc/BRIEF.md
# Temperature-Adaptive Per-Bank Refresh Scheduler

This block keeps every bank of an eight-bank DRAM refreshed, one bank at a time, so that the other banks stay usable. A free-running interval counter produces one refresh tick per interval. On each tick the scheduler asks the command sequencer to refresh the next bank in rotation. The request carries the bank index and is held until the sequencer grants it.

The length of the interval is not fixed. It is looked up in a parameter table, indexed by a 3-bit rate code that the DRAM reports from its temperature-status mode register. On a fixed period the scheduler asks for that register to be read. It captures the code that comes back, and the code is applied when the interval counter next reloads. Code 7 is the hottest condition and has the shortest interval, which corresponds to 0.9 µs per bank.

A per-bank request may stay ungranted for too long. When this happens, the scheduler replaces it with a single all-bank refresh request and sets an overdue flag that stays set until reset.

Top module: `refresh_sched`

## Requirements
- R1: After reset: `refReq`, `refAllBank`, `mrReq` and `overdue` are low, `refBank` is 0, and `rateCode` equals `RESET_CODE`.
- R2: The first refresh request rises `RATE_TABLE[RESET_CODE]` cycles after reset is released. When every request is granted at once, successive requests rise exactly one interval of the active code apart.
- R3: Per-bank requests name banks 0,1,…,7 in turn and then wrap to 0. `refBank` does not change while a request waits.
- R4: A request stays high until `refGnt` is seen high with it. The request falls in the cycle after the grant.
- R5: `mrReq` rises `POLL_PERIOD` cycles after reset and then every `POLL_PERIOD` cycles. It stays high until `mrAck`. `mrCode` is captured only on a cycle where both `mrReq` and `mrAck` are high.
- R6: A captured code takes effect at the next interval reload. The interval that follows the reload is `RATE_TABLE[code]` cycles long, and `rateCode` then shows that code.
- R7: A per-bank request may stay ungranted through `overdueLimit` further ticks. At the next tick after those, it becomes an all-bank request: `refAllBank` goes high with `refReq`, and `overdue` is set.
- R8: `overdue` stays set. After an all-bank request is granted, rotation restarts at bank 0 with per-bank requests.
- R9: With `overdueLimit` = 0, the first tick that finds a request still waiting escalates it to an all-bank request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGnt | input | 1 | Sequencer accepts the pending refresh request |
| mrAck | input | 1 | Mode-register read done; `mrCode` valid |
| mrCode | input | CODE_W | Temperature rate code from the status register |
| overdueLimit | input | LIM_W | Missed ticks tolerated before escalation |
| refReq | output | 1 | Refresh request pending |
| refAllBank | output | 1 | Pending request is an all-bank refresh |
| refBank | output | BANK_W | Bank for a per-bank request |
| mrReq | output | 1 | Status mode-register read request |
| overdue | output | 1 | Sticky flag: an escalation has occurred |
| rateCode | output | CODE_W | Rate code currently governing the interval |

## Verification
The bench runs with a small table in which code c gives an interval of 40−4c cycles. With immediate grants, it checks the first request, then sixteen requests to see the bank order wrap, and also the spacing of the poll requests. Each of the eight codes is then returned in turn, and the interval after the following reload is measured. Because every code has a distinct interval, this shows that a code is both captured and applied one reload later. With grants withheld, the bench checks that escalation lands on exactly the (limit+1)-th tick for limit 2 and limit 0. This separates an off-by-one in the miss count from a correct design. After the all-bank grant, it checks that the flag stays set and that rotation restarts at bank 0.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic ldCode;   // capture returned rate code
    logic advBank;  // step rotation pointer
    logic rstBank;  // restart rotation at bank 0
    logic incMiss;  // one more missed tick
    logic clrMiss;  // clear missed-tick count
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BANK = 2'd1,
    ST_ALL  = 2'd2
  } reqState_e;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int CODE_W      = 3,
  parameter int CNT_W       = 16,
  parameter int POLL_PERIOD = 16000,
  parameter int LIM_W       = 4,
  parameter int RESET_CODE  = 3,
  parameter logic [(1<<CODE_W)-1:0][CNT_W-1:0] RATE_TABLE = '0,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int POLL_W = (POLL_PERIOD > 1) ? $clog2(POLL_PERIOD) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [CODE_W-1:0] mrCode,
  input  logic [LIM_W-1:0]  overdueLimit,
  output logic              tick,
  output logic              pollTick,
  output logic              missAtLimit,
  output logic [BANK_W-1:0] bankPtr,
  output logic [CODE_W-1:0] activeCode
);

  localparam logic [BANK_W-1:0] LAST_BANK  = BANK_W'(NUM_BANKS - 1);
  localparam logic [POLL_W-1:0] POLL_LOAD  = POLL_W'(POLL_PERIOD - 1);
  localparam logic [CODE_W-1:0] START_CODE = CODE_W'(RESET_CODE);

  function automatic logic [CNT_W-1:0] reloadOf(input logic [CODE_W-1:0] c);
    return RATE_TABLE[c] - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0]  intCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [CODE_W-1:0] pendCode;
  logic [LIM_W-1:0]  missCnt;

  assign tick        = (intCnt == '0);
  assign pollTick    = (pollCnt == '0);
  assign missAtLimit = (missCnt >= overdueLimit);

  // interval counter; code switch happens only on reload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCnt     <= reloadOf(START_CODE);
      activeCode <= START_CODE;
    end else if (tick) begin
      intCnt     <= reloadOf(pendCode);
      activeCode <= pendCode;
    end else begin
      intCnt     <= intCnt - CNT_W'(1);
    end
  end

  // status-register poll timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pollCnt <= POLL_LOAD;
    else if (pollTick) pollCnt <= POLL_LOAD;
    else               pollCnt <= pollCnt - POLL_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pendCode <= START_CODE;
    else if (ctl.ldCode) pendCode <= mrCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  bankPtr <= '0;
    else if (ctl.rstBank)       bankPtr <= '0;
    else if (ctl.advBank)       bankPtr <= (bankPtr == LAST_BANK) ? '0 : bankPtr + BANK_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            missCnt <= '0;
    else if (ctl.clrMiss) missCnt <= '0;
    else if (ctl.incMiss) missCnt <= missCnt + LIM_W'(1);
  end

  // R3
  bank_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankPtr <= LAST_BANK);

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(activeCode));

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   tick,
  input  logic   pollTick,
  input  logic   missAtLimit,
  input  logic   refGnt,
  input  logic   mrAck,
  output dpCtl_t ctl,
  output logic   refReq,
  output logic   refAllBank,
  output logic   mrReq,
  output logic   overdue
);

  reqState_e st, stNext;
  logic      escalate;

  always_comb begin
    stNext     = st;
    ctl        = '0;
    escalate   = 1'b0;
    ctl.ldCode = mrReq & mrAck;
    case (st)
      ST_IDLE: begin
        if (tick) stNext = ST_BANK;
      end
      ST_BANK: begin
        if (refGnt) begin
          ctl.advBank = 1'b1;
          ctl.clrMiss = 1'b1;
          stNext      = tick ? ST_BANK : ST_IDLE;
        end else if (tick) begin
          if (missAtLimit) begin
            stNext      = ST_ALL;
            ctl.clrMiss = 1'b1;
            escalate    = 1'b1;
          end else begin
            ctl.incMiss = 1'b1;
          end
        end
      end
      ST_ALL: begin
        if (refGnt) begin
          ctl.rstBank = 1'b1;
          ctl.clrMiss = 1'b1;
          stNext      = tick ? ST_BANK : ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      overdue <= 1'b0;
      mrReq   <= 1'b0;
    end else begin
      st      <= stNext;
      overdue <= overdue | escalate;
      if (pollTick)   mrReq <= 1'b1;
      else if (mrAck) mrReq <= 1'b0;
    end
  end

  assign refReq     = (st != ST_IDLE);
  assign refAllBank = (st == ST_ALL);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq && !refGnt |=> refReq);

  // R5
  mr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mrReq && !mrAck |=> mrReq);

  // R8
  overdue_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overdue |=> overdue);

  // R7
  all_bank_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    refAllBank |-> overdue);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int CODE_W      = 3,
  parameter int CNT_W       = 16,
  parameter int POLL_PERIOD = 16000,
  parameter int LIM_W       = 4,
  parameter int RESET_CODE  = 3,
  // per-bank interval in cycles, indexed by rate code (code 7 hottest)
  parameter logic [(1<<CODE_W)-1:0][CNT_W-1:0] RATE_TABLE =
    {16'd360, 16'd540, 16'd720, 16'd1080, 16'd1440, 16'd2160, 16'd2880, 16'd3600},
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refGnt,
  input  logic              mrAck,
  input  logic [CODE_W-1:0] mrCode,
  input  logic [LIM_W-1:0]  overdueLimit,
  output logic              refReq,
  output logic              refAllBank,
  output logic [BANK_W-1:0] refBank,
  output logic              mrReq,
  output logic              overdue,
  output logic [CODE_W-1:0] rateCode
);

  dpCtl_t ctl;
  logic   tick, pollTick, missAtLimit;

  refsched_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .pollTick   (pollTick),
    .missAtLimit(missAtLimit),
    .refGnt     (refGnt),
    .mrAck      (mrAck),
    .ctl        (ctl),
    .refReq     (refReq),
    .refAllBank (refAllBank),
    .mrReq      (mrReq),
    .overdue    (overdue)
  );

  refsched_dp #(
    .NUM_BANKS  (NUM_BANKS),
    .CODE_W     (CODE_W),
    .CNT_W      (CNT_W),
    .POLL_PERIOD(POLL_PERIOD),
    .LIM_W      (LIM_W),
    .RESET_CODE (RESET_CODE),
    .RATE_TABLE (RATE_TABLE)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .mrCode      (mrCode),
    .overdueLimit(overdueLimit),
    .tick        (tick),
    .pollTick    (pollTick),
    .missAtLimit (missAtLimit),
    .bankPtr     (refBank),
    .activeCode  (rateCode)
  );

  // R3
  bank_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq && !refGnt |=> $stable(refBank));

  // R8
  rotation_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    refAllBank && refGnt |=> refBank == '0);

endmodule

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;

  localparam int CNT_W = 8;
  localparam int POLL  = 20;

  function automatic int expInt(input int c);
    return 40 - 4 * c;
  endfunction

  function automatic logic [7:0][CNT_W-1:0] makeTable();
    logic [7:0][CNT_W-1:0] t;
    for (int c = 0; c < 8; c++) t[c] = CNT_W'(expInt(c));
    return t;
  endfunction

  localparam logic [7:0][CNT_W-1:0] TB_TABLE = makeTable();

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refGnt = 1'b0;
  logic       mrAck = 1'b0;
  logic [2:0] mrCode = 3'd0;
  logic [3:0] overdueLimit = 4'd2;
  logic       refReq, refAllBank, mrReq, overdue;
  logic [2:0] refBank, rateCode;

  refresh_sched #(
    .NUM_BANKS(8), .CODE_W(3), .CNT_W(CNT_W), .POLL_PERIOD(POLL),
    .LIM_W(4), .RESET_CODE(3), .RATE_TABLE(TB_TABLE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .mrAck(mrAck), .mrCode(mrCode),
    .overdueLimit(overdueLimit), .refReq(refReq), .refAllBank(refAllBank),
    .refBank(refBank), .mrReq(mrReq), .overdue(overdue), .rateCode(rateCode)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) if (!rstN) cyc <= 0; else cyc <= cyc + 1;

  int  checks = 0, errors = 0;
  bit  done = 0;
  bit  autoGrant = 1;
  int  desiredCode = 3;
  int  riseCount = 0, lastRiseCyc = 0, lastRiseBank = 0, lastRiseAll = 0;
  int  mrRiseCount = 0, mrLastCyc = 0, mrPrevCyc = 0, ackCount = 0;
  bit  refPrev = 0, mrPrev = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic waitRise();
    int n = riseCount;
    do step(); while (riseCount == n);
  endtask

  // monitors and responders, all at the falling edge
  initial forever begin
    @(negedge clk);
    if (rstN && refReq && !refPrev) begin
      riseCount++; lastRiseCyc = cyc; lastRiseBank = int'(refBank); lastRiseAll = int'(refAllBank);
    end
    refPrev = refReq;
    if (rstN && mrReq && !mrPrev) begin
      mrRiseCount++; mrPrevCyc = mrLastCyc; mrLastCyc = cyc;
    end
    mrPrev = mrReq;
    refGnt = autoGrant && refReq && rstN;
    if (rstN && mrReq && !mrAck) begin
      mrAck = 1'b1; mrCode = 3'(desiredCode); ackCount++;
    end else begin
      mrAck = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finishRun();
  end

  initial begin
    int t0, b, n;
    bit held;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(refReq == 0 && refAllBank == 0, "R1 req", int'(refReq), 0);
    chk(mrReq == 0, "R1 mrReq", int'(mrReq), 0);
    chk(overdue == 0, "R1 overdue", int'(overdue), 0);
    chk(refBank == 0, "R1 bank", int'(refBank), 0);
    chk(rateCode == 3, "R1 rateCode", int'(rateCode), 3);
    @(negedge clk); rstN = 1'b1;

    // R2 first request, R3 rotation, R4 grant clears
    waitRise();
    chk(lastRiseCyc == expInt(3), "R2 first request", lastRiseCyc, expInt(3));
    chk(mrRiseCount == 1 && mrLastCyc == POLL, "R5 first poll", mrLastCyc, POLL);
    chk(lastRiseBank == 0, "R3 bank order", lastRiseBank, 0);
    step();
    chk(refReq == 0, "R4 grant clears", int'(refReq), 0);
    for (int i = 1; i < 16; i++) begin
      t0 = lastRiseCyc;
      waitRise();
      chk(lastRiseCyc - t0 == expInt(3), "R2 spacing", lastRiseCyc - t0, expInt(3));
      chk(lastRiseBank == i % 8, "R3 bank order", lastRiseBank, i % 8);
    end
    chk(mrLastCyc - mrPrevCyc == POLL, "R5 poll period", mrLastCyc - mrPrevCyc, POLL);

    // R6 sweep every code
    for (int c = 0; c < 8; c++) begin
      desiredCode = c;
      n = ackCount;
      do step(); while (ackCount == n);
      step(); step();
      waitRise();
      t0 = lastRiseCyc;
      waitRise();
      chk(lastRiseCyc - t0 == expInt(c), "R6 interval", lastRiseCyc - t0, expInt(c));
      chk(int'(rateCode) == c, "R6 rateCode", int'(rateCode), c);
    end
    chk(overdue == 0, "R7 no early overdue", int'(overdue), 0);

    // R7 escalation with limit 2 (code 7 -> 12 cycles)
    autoGrant = 0; overdueLimit = 4'd2;
    waitRise();
    b = lastRiseBank;
    held = 1;
    for (int k = 1; k < 3 * expInt(7); k++) begin
      step();
      if (!refReq || int'(refBank) != b || refAllBank) held = 0;
    end
    chk(held, "R4 request held", int'(held), 1);
    step();
    chk(refAllBank == 1 && refReq == 1, "R7 all-bank", int'(refAllBank), 1);
    chk(overdue == 1, "R7 overdue", int'(overdue), 1);

    // R8 sticky flag and rotation restart
    autoGrant = 1;
    do step(); while (refReq);
    chk(overdue == 1, "R8 sticky", int'(overdue), 1);
    waitRise();
    chk(lastRiseBank == 0 && lastRiseAll == 0, "R8 restart bank", lastRiseBank, 0);

    // R9 limit 0 escalates on first missed tick
    step();
    autoGrant = 0; overdueLimit = 4'd0;
    waitRise();
    chk(lastRiseAll == 0, "R9 starts per-bank", lastRiseAll, 0);
    repeat (expInt(7) - 1) step();
    chk(refAllBank == 0, "R9 before tick", int'(refAllBank), 0);
    step();
    chk(refAllBank == 1, "R9 escalate", int'(refAllBank), 1);
    autoGrant = 1;
    do step(); while (refReq);
    chk(overdue == 1, "R8 sticky end", int'(overdue), 1);

    finishRun();
  end

endmodule